// File: doc/BRIEF.md
# Variable Byte Permute Unit

This block rearranges the bytes of a data operand under the control of a second operand of the same width. Control byte i decides output byte i. Its low bits name the data byte copied into that position. Its top bit, when set, forces the output byte to zero instead. Any source byte may go to any position, and one source byte may fill several positions.

Each request selects one of two widths. The half form works on 8 bytes and returns its result one cycle after the request. The full form works on 16 bytes and returns its result three cycles after the request. Results always leave in request order. A half-width request issued close behind a full-width one therefore stays behind it and may take two or three cycles. One request is accepted every cycle and none is ever dropped.

Top module: `byte_permute_unit`

## Requirements
- R1: In full mode (req_wide=1), output byte i (bits 8i+7..8i) equals data byte k, where k is bits 3..0 of control byte i.
- R2: In half mode (req_wide=0), k is bits 2..0 of control byte i. Bits 6..3 of each control byte have no effect on the result.
- R3: In full mode, bits 6..4 of each control byte have no effect on the result.
- R4: When bit 7 of control byte i is set, output byte i is 0x00 whatever the other bits hold. This includes a control value of 0xFF.
- R5: Any data byte may be copied to any output position, and the same data byte may appear in several positions.
- R6: In half mode, result bits 127..64 are zero, and the upper 64 bits of both data and control have no effect.
- R7: A half-mode request made when no earlier request is still in flight gives res_valid and its result in the next cycle.
- R8: A full-mode request gives res_valid and its result exactly three cycles after the request cycle.
- R9: Results leave in request order. A half-mode request that follows a full-mode request still in flight comes out in the cycle after that full-mode result.
- R10: While reset is asserted, and after a reset taken with requests in flight, res_valid is 0 until a new request is made.
- R11: A request accepted in every cycle produces one result per request, with none lost or duplicated.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| req_valid | input | 1 | A request is present this cycle |
| req_wide | input | 1 | 1 selects the 16-byte form, 0 the 8-byte form |
| req_data | input | 128 | Data operand whose bytes are rearranged |
| req_ctrl | input | 128 | One control byte per output byte |
| res_valid | output | 1 | res_data holds a result this cycle |
| res_data | output | 128 | Permuted result |

## Verification
On every cycle the assertions check three things. A set zero flag always yields a zero byte at the selector output. Half-width results reaching the port have a zero upper half. Occupied result stages advance by one place per cycle, so nothing is lost inside the ordering pipe. The assertions also check that each request lands in the stage its width and the pipe occupancy call for. Only the bench scenarios can show that the selected byte is the right one, that ignored control bits really have no effect, and the cycle counts seen at the port. The same holds for the ordering when a half-width request trails a full-width one by one or two cycles, and for a reset taken while results are in flight.

// File: rtl/bpu_pkg.sv
package bpu_pkg;
  localparam int BYTE_W   = 8;
  localparam int ZERO_BIT = 7;

  typedef enum logic {
    WIDTH_HALF = 1'b0,
    WIDTH_FULL = 1'b1
  } bpu_width_e;
endpackage

// File: rtl/bpu_lane_sel.sv
module bpu_lane_sel
  import bpu_pkg::*;
#(
  parameter int BYTES = 16
) (
  input  logic [BYTES*BYTE_W-1:0] data_i,
  input  logic                    zero_i,
  input  logic [$clog2(BYTES)-1:0] idx_i,
  input  logic                    wide_i,
  output logic [BYTE_W-1:0]       byte_o
);
  localparam int IDX_W = $clog2(BYTES);

  logic [IDX_W-1:0] idx_eff;

  // In the half form the top index bit is dropped, so only the lower half of the data is reachable
  always_comb begin
    idx_eff = idx_i;
    if (!wide_i) idx_eff[IDX_W-1] = 1'b0;
    byte_o = zero_i ? '0 : data_i[idx_eff*BYTE_W +: BYTE_W];
  end
endmodule

// File: rtl/bpu_permute_core.sv
module bpu_permute_core
  import bpu_pkg::*;
#(
  parameter int BYTES = 16
) (
  input  logic [BYTES*BYTE_W-1:0] data_i,
  input  logic [BYTES*BYTE_W-1:0] ctrl_i,
  input  logic                    wide_i,
  output logic [BYTES*BYTE_W-1:0] perm_o
);
  localparam int IDX_W = $clog2(BYTES);
  localparam int HALF  = BYTES / 2;

  for (genvar i = 0; i < BYTES; i++) begin : g_lane
    logic [BYTE_W-1:0] sel_byte;

    bpu_lane_sel #(.BYTES(BYTES)) u_sel (
      .data_i (data_i),
      .zero_i (ctrl_i[i*BYTE_W + ZERO_BIT]),
      .idx_i  (ctrl_i[i*BYTE_W +: IDX_W]),
      .wide_i (wide_i),
      .byte_o (sel_byte)
    );

    if (i < HALF) begin : g_low
      assign perm_o[i*BYTE_W +: BYTE_W] = sel_byte;
    end else begin : g_high
      // upper lanes only exist in the full form
      assign perm_o[i*BYTE_W +: BYTE_W] = wide_i ? sel_byte : '0;
    end
  end
endmodule

// File: rtl/bpu_order_pipe.sv
module bpu_order_pipe #(
  parameter int W          = 128,
  parameter int WIDE_LAT   = 3,
  parameter int NARROW_LAT = 1
) (
  input  logic         clk,
  input  logic         rst_ni,
  input  logic         in_valid,
  input  logic         in_wide,
  input  logic [W-1:0] in_data,
  output logic         out_valid,
  output logic [W-1:0] out_data
);
  localparam int DEPTH        = WIDE_LAT;
  localparam int NARROW_ENTRY = DEPTH - NARROW_LAT;

  logic [DEPTH-1:0] vld_q, vld_d;
  logic [DEPTH-1:0] wide_q, wide_d;
  logic [DEPTH-1:0] load_en;
  logic [DEPTH-1:0] entry_oh;
  logic [W-1:0]     dat_q [DEPTH];
  logic [W-1:0]     dat_d [DEPTH];

  // Entry stage: full width always at the head. Half width goes to its own
  // stage, or directly behind the youngest older entry if one is ahead of it.
  always_comb begin
    logic found;
    entry_oh = '0;
    found    = 1'b0;
    if (in_valid) begin
      if (in_wide) begin
        entry_oh[0] = 1'b1;
      end else begin
        for (int j = 0; j < DEPTH; j++) begin
          if (!found && ((j < DEPTH-1 && vld_q[j]) || j == NARROW_ENTRY)) begin
            entry_oh[j] = 1'b1;
            found       = 1'b1;
          end
        end
      end
    end
  end

  // Next state: every stage shifts one place toward the output
  always_comb begin
    for (int s = 0; s < DEPTH; s++) begin
      if (entry_oh[s]) begin
        vld_d[s]  = 1'b1;
        wide_d[s] = in_wide;
        dat_d[s]  = in_data;
      end else if (s > 0) begin
        vld_d[s]  = vld_q[s-1];
        wide_d[s] = wide_q[s-1];
        dat_d[s]  = dat_q[s-1];
      end else begin
        vld_d[s]  = 1'b0;
        wide_d[s] = 1'b0;
        dat_d[s]  = dat_q[s];
      end
      load_en[s] = vld_d[s];
    end
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) vld_q <= '0;
    else         vld_q <= vld_d;
  end

  for (genvar s = 0; s < DEPTH; s++) begin : g_stage
    always_ff @(posedge clk) begin
      if (load_en[s]) begin
        dat_q[s]  <= dat_d[s];
        wide_q[s] <= wide_d[s];
      end
    end

    if (s < DEPTH-1) begin : g_adv
      AST_STAGE_ADVANCE: assert property (@(posedge clk) disable iff (!rst_ni)
        vld_q[s] |=> vld_q[s+1]);  // R11
    end
  end

  assign out_valid = vld_q[DEPTH-1];
  assign out_data  = dat_q[DEPTH-1];

  AST_FULL_ENTERS_HEAD: assert property (@(posedge clk) disable iff (!rst_ni)
    in_valid && in_wide |=> vld_q[0] && wide_q[0]);  // R8

  AST_HALF_FAST_PATH: assert property (@(posedge clk) disable iff (!rst_ni)
    in_valid && !in_wide && !(|vld_q[DEPTH-2:0]) |=> vld_q[NARROW_ENTRY] && !wide_q[NARROW_ENTRY]);  // R7

  AST_HALF_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_ni)
    out_valid && !wide_q[DEPTH-1] |-> out_data[W-1:W/2] == '0);  // R6
endmodule

// File: rtl/byte_permute_unit.sv
module byte_permute_unit
  import bpu_pkg::*;
#(
  parameter int BYTES      = 16,
  parameter int WIDE_LAT   = 3,
  parameter int NARROW_LAT = 1
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    req_valid,
  input  logic                    req_wide,
  input  logic [BYTES*8-1:0]      req_data,
  input  logic [BYTES*8-1:0]      req_ctrl,
  output logic                    res_valid,
  output logic [BYTES*8-1:0]      res_data
);
  localparam int W = BYTES * BYTE_W;

  logic       rst_meta_q, rst_sync_q;
  bpu_width_e req_mode;
  logic       mode_full;
  logic [W-1:0] perm;

  // reset asserts at once, deasserts on the second clock edge
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_q <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_q <= rst_meta_q;
    end
  end

  assign req_mode  = bpu_width_e'(req_wide);
  assign mode_full = (req_mode == WIDTH_FULL);

  bpu_permute_core #(.BYTES(BYTES)) u_core (
    .data_i (req_data),
    .ctrl_i (req_ctrl),
    .wide_i (mode_full),
    .perm_o (perm)
  );

  bpu_order_pipe #(
    .W          (W),
    .WIDE_LAT   (WIDE_LAT),
    .NARROW_LAT (NARROW_LAT)
  ) u_pipe (
    .clk       (clk),
    .rst_ni    (rst_sync_q),
    .in_valid  (req_valid),
    .in_wide   (mode_full),
    .in_data   (perm),
    .out_valid (res_valid),
    .out_data  (res_data)
  );

  for (genvar i = 0; i < BYTES; i++) begin : g_zchk
    AST_ZERO_FLAG_WINS: assert property (@(posedge clk) disable iff (!rst_sync_q)
      req_valid && req_ctrl[i*BYTE_W + ZERO_BIT] |-> perm[i*BYTE_W +: BYTE_W] == '0);  // R4
  end
endmodule

// File: tb/byte_permute_unit_test.sv
`timescale 1ns/1ps
module byte_permute_unit_test;
  logic         clk = 1'b0;
  logic         rst_n;
  logic         req_valid;
  logic         req_wide;
  logic [127:0] req_data;
  logic [127:0] req_ctrl;
  logic         res_valid;
  logic [127:0] res_data;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  always #2 clk = ~clk;

  byte_permute_unit uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_wide(req_wide),
    .req_data(req_data), .req_ctrl(req_ctrl), .res_valid(res_valid), .res_data(res_data)
  );

  typedef struct packed {
    logic         wide;
    logic [127:0] data;
    logic [127:0] ctrl;
    logic [127:0] exp;
  } vec_t;

  localparam logic [127:0] SEQ = 128'h0F0E0D0C0B0A09080706050403020100;

  localparam vec_t VECS [6] = '{
    // R1: full-width byte reversal
    '{1'b1, SEQ, 128'h000102030405060708090A0B0C0D0E0F, 128'h000102030405060708090A0B0C0D0E0F},
    // R4 R5: 0x80 and 0xFF give zero, index 5 fans out
    '{1'b1, SEQ, 128'h0505050505050505050505050505FF80, 128'h05050505050505050505050505050000},
    // R3: bits 6..4 set everywhere, identity result
    '{1'b1, SEQ, 128'h7F7E7D7C7B7A79787776757473727170, SEQ},
    // R2 R6: bits 6..3 set, junk in upper control
    '{1'b0, SEQ, 128'h03030303030303037879_7A7B7C7D7E7F, 128'h00000000000000000001020304050607},
    // R2: index 15 folds to 7 in half mode
    '{1'b0, SEQ, 128'h00000000000000000F0F0F0F0F0F0F0F, 128'h00000000000000000707070707070707},
    // R5: one source byte to every lane
    '{1'b1, 128'hFFEEDDCCBBAA99887766554433221100, {16{8'h03}}, {16{8'h33}}}
  };

  function automatic logic [127:0] model(input logic wide, input logic [127:0] d, input logic [127:0] c);
    logic [127:0] r;
    logic [3:0]   ix;
    r = '0;
    for (int i = 0; i < 16; i++) begin
      if (wide || i < 8) begin
        ix = wide ? c[i*8 +: 4] : {1'b0, c[i*8 +: 3]};
        r[i*8 +: 8] = c[i*8+7] ? 8'h00 : d[ix*8 +: 8];
      end
    end
    return r;
  endfunction

  task automatic chk(input string tag, input logic [127:0] act, input logic [127:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic drive(input logic v, input logic w, input logic [127:0] d, input logic [127:0] c);
    req_valid = v; req_wide = w; req_data = d; req_ctrl = c;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    logic [127:0] ca, cb, cc, da;
    rst_n = 1'b0;
    drive(1'b0, 1'b0, '0, '0);
    repeat (3) @(negedge clk);
    chk("R10 valid in reset", {127'b0, res_valid}, 128'd0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R10 valid after reset", {127'b0, res_valid}, 128'd0);

    // table walk: one request, then watch the exact arrival cycle
    for (int v = 0; v < 6; v++) begin
      drive(1'b1, VECS[v].wide, VECS[v].data, VECS[v].ctrl);
      @(negedge clk);
      drive(1'b0, 1'b0, '0, '0);
      if (VECS[v].wide) begin
        chk($sformatf("R8 vec%0d not early c1", v), {127'b0, res_valid}, 128'd0);
        @(negedge clk);
        chk($sformatf("R8 vec%0d not early c2", v), {127'b0, res_valid}, 128'd0);
        @(negedge clk);
      end
      chk($sformatf("R7 R8 vec%0d valid", v), {127'b0, res_valid}, 128'd1);
      chk($sformatf("R1 vec%0d data", v), res_data, VECS[v].exp);
      @(negedge clk);
      chk($sformatf("R11 vec%0d single", v), {127'b0, res_valid}, 128'd0);
    end

    // R9: half request one cycle behind a full one
    da = 128'h8899AABBCCDDEEFF0011223344556677;
    ca = 128'h0F0E0D0C0B0A09080706050403020100 ^ 128'h0F0F0F0F0F0F0F0F0F0F0F0F0F0F0F0F;
    cb = 128'hAAAAAAAAAAAAAAAA0001020304058007;
    drive(1'b1, 1'b1, da, ca);
    @(negedge clk);
    drive(1'b1, 1'b0, da, cb);
    @(negedge clk);
    drive(1'b0, 1'b0, '0, '0);
    chk("R9 half waits c2", {127'b0, res_valid}, 128'd0);
    @(negedge clk);
    chk("R9 full first valid", {127'b0, res_valid}, 128'd1);
    chk("R9 full first data", res_data, model(1'b1, da, ca));
    @(negedge clk);
    chk("R9 half second valid", {127'b0, res_valid}, 128'd1);
    chk("R9 half second data", res_data, model(1'b0, da, cb));
    @(negedge clk);
    chk("R9 drained", {127'b0, res_valid}, 128'd0);

    // R9: half request two cycles behind a full one
    drive(1'b1, 1'b1, da, cb);
    @(negedge clk);
    drive(1'b0, 1'b0, '0, '0);
    @(negedge clk);
    drive(1'b1, 1'b0, da, ca);
    @(negedge clk);
    drive(1'b0, 1'b0, '0, '0);
    chk("R9 gap full data", res_data, model(1'b1, da, cb));
    @(negedge clk);
    chk("R9 gap half valid", {127'b0, res_valid}, 128'd1);
    chk("R9 gap half data", res_data, model(1'b0, da, ca));
    @(negedge clk);

    // R11: three half requests back to back
    cc = 128'h0000000000000000_0203040506070001;
    drive(1'b1, 1'b0, da, ca);
    @(negedge clk);
    chk("R11 b2b first", res_data, model(1'b0, da, ca));
    drive(1'b1, 1'b0, da, cb);
    @(negedge clk);
    chk("R11 b2b second", res_data, model(1'b0, da, cb));
    drive(1'b1, 1'b0, da, cc);
    @(negedge clk);
    chk("R11 b2b third", res_data, model(1'b0, da, cc));
    drive(1'b0, 1'b0, '0, '0);
    @(negedge clk);
    chk("R11 b2b end", {127'b0, res_valid}, 128'd0);

    // R10: reset with a full request in flight
    drive(1'b1, 1'b1, da, ca);
    @(negedge clk);
    drive(1'b0, 1'b0, '0, '0);
    rst_n = 1'b0;
    @(negedge clk);
    chk("R10 flush in reset", {127'b0, res_valid}, 128'd0);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    chk("R10 no stale result", {127'b0, res_valid}, 128'd0);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule